// File: doc/BRIEF.md
# Bounds-Check Compare Unit

This block is purely combinational. It decides whether a 32-bit register value lies inside an inclusive range set by a lower bound and an upper bound. The bounds can be byte, word or long in size. The unit computes two fresh condition bits:

- **equal-to-bound (Z):** the value equals one of the bounds.
- **outside-range (C):** the value is outside the range.

The extend, negative and overflow bits are copied unchanged from the incoming flags. A separate `out_of_range` output repeats C so that downstream logic can raise a trap. Fetching the bound pair from memory and generating the trap both happen outside this block.

The range test does not use signed comparisons. It measures the value's offset from the lower bound and the span of the range, both as unsigned 32-bit quantities, and compares those. A value below the lower bound wraps to a huge offset and is flagged. When the lower bound is greater than the upper bound, the accepted set is the wrapped interval from lower up to upper.

How the tested value is widened depends on the register class. A value from a data register is sign-extended from the selected size. A value from an address register is always used at its full 32 bits.

Top module: `bchk_unit`

## Requirements
- R1: For `size_sel` 0 (byte) the bounds are taken from bits 7:0 and sign-extended; for 1 (word) from bits 15:0 and sign-extended. For 2 (long) and 3 (treated as long) all 32 bits are used.
- R2: When `addr_reg` is 0 (data register), the tested value is sign-extended from bits 7:0 at byte size and from bits 15:0 at word size.
- R3: When `addr_reg` is 1 (address register), the tested value is the full 32-bit `reg_val` at every size.
- R4: Z (`flags_out` bit 2) is 1 exactly when the extended value equals the extended lower bound or the extended upper bound.
- R5: C (`flags_out` bit 0) is 1 exactly when (value − lower) mod 2^32, read as unsigned, is greater than (upper − lower) mod 2^32, read as unsigned.
- R6: `flags_out` bits 4 (X), 3 (N) and 1 (V) equal the same bits of `flags_in`. The bit order is C=0, V=1, Z=2, N=3, X=4.
- R7: `out_of_range` equals `flags_out` bit 0 at all times.
- R8: At byte and word size, input bits above the selected size in `bound_lo`, `bound_hi` and (for data registers) `reg_val` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_val | input | 32 | Register value under test |
| bound_lo | input | 32 | Lower bound (first of the pair), right-aligned |
| bound_hi | input | 32 | Upper bound (second of the pair), right-aligned |
| size_sel | input | 2 | 0 byte, 1 word, 2/3 long |
| addr_reg | input | 1 | 1 when the value comes from an address register |
| flags_in | input | 5 | Incoming condition bits {X,N,Z,V,C} |
| flags_out | output | 5 | Resulting condition bits {X,N,Z,V,C} |
| out_of_range | output | 1 | Copy of the C result for a trap request |

## Verification
The hardest cases are the ones where the unsigned offset test and a naive signed compare disagree:

- reversed bound pairs, where the lower bound is greater than the upper bound and the range wraps;
- values exactly on the upper bound while the lower bound differs;
- address-register tests at byte size, where the high bits of `reg_val` must be kept.

Random stimulus rarely lands on these. Directed vectors therefore build each one explicitly: equal bounds, inverted pairs, and values one step either side of each bound. A random phase then follows in which the value is often copied from a bound and the high bits are filled with noise.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned FLAG_W = 5;

  localparam int unsigned F_C = 0;
  localparam int unsigned F_V = 1;
  localparam int unsigned F_Z = 2;
  localparam int unsigned F_N = 3;
  localparam int unsigned F_X = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  function automatic logic [DW-1:0] sext_by_size(input logic [DW-1:0] x, input size_e sz);
    logic [DW-1:0] r;
    unique case (sz)
      SZ_BYTE: r = {{(DW-BYTE_W){x[BYTE_W-1]}}, x[BYTE_W-1:0]};
      SZ_WORD: r = {{(DW-WORD_W){x[WORD_W-1]}}, x[WORD_W-1:0]};
      default: r = x;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] wrap_diff(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a - b;
  endfunction
endpackage

// File: rtl/bchk_extend.sv
module bchk_extend
  import bchk_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] raw,
  input  logic [1:0]   size_sel,
  input  logic         keep_full,
  output logic [W-1:0] ext
);
  always_comb begin
    if (keep_full) ext = raw;
    else           ext = sext_by_size(raw, size_e'(size_sel));
  end
endmodule

// File: rtl/bchk_range.sv
module bchk_range
  import bchk_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] offset,
  output logic [W-1:0] span,
  output logic         on_bound,
  output logic         outside
);
  always_comb begin
    offset   = wrap_diff(val, lo);
    span     = wrap_diff(hi, lo);
    on_bound = (offset == '0) || (offset == span);
    outside  = offset > span;
  end
endmodule

// File: rtl/bchk_flags.sv
module bchk_flags
  import bchk_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              new_z,
  input  logic              new_c,
  output logic [FLAG_W-1:0] flags_out
);
  always_comb begin
    flags_out      = flags_in;
    flags_out[F_Z] = new_z;
    flags_out[F_C] = new_c;
  end
endmodule

// File: rtl/bchk_unit.sv
module bchk_unit
  import bchk_pkg::*;
(
  input  logic [31:0] reg_val,
  input  logic [31:0] bound_lo,
  input  logic [31:0] bound_hi,
  input  logic [1:0]  size_sel,
  input  logic        addr_reg,
  input  logic [4:0]  flags_in,
  output logic [4:0]  flags_out,
  output logic        out_of_range
);
  logic [DW-1:0] ext_val, ext_lo, ext_hi;
  logic [DW-1:0] offset, span;
  logic          hit_bound, outside;

  bchk_extend #(.W(DW)) u_ext_val (.raw(reg_val),  .size_sel(size_sel), .keep_full(addr_reg), .ext(ext_val));
  bchk_extend #(.W(DW)) u_ext_lo  (.raw(bound_lo), .size_sel(size_sel), .keep_full(1'b0),     .ext(ext_lo));
  bchk_extend #(.W(DW)) u_ext_hi  (.raw(bound_hi), .size_sel(size_sel), .keep_full(1'b0),     .ext(ext_hi));

  bchk_range #(.W(DW)) u_range (
    .val(ext_val), .lo(ext_lo), .hi(ext_hi),
    .offset(offset), .span(span), .on_bound(hit_bound), .outside(outside)
  );

  bchk_flags u_flags (.flags_in(flags_in), .new_z(hit_bound), .new_c(outside), .flags_out(flags_out));

  assign out_of_range = outside;
endmodule

// File: rtl/bchk_unit_chk.sv
module bchk_unit_chk (
  input logic [31:0] reg_val,
  input logic [1:0]  size_sel,
  input logic        addr_reg,
  input logic [4:0]  flags_in,
  input logic [4:0]  flags_out,
  input logic        out_of_range,
  input logic [31:0] ext_val,
  input logic [31:0] ext_lo,
  input logic [31:0] ext_hi
);
  always_comb begin
    if (!$isunknown({reg_val, size_sel, addr_reg, flags_in, ext_val, ext_lo, ext_hi})) begin
      a_r6_passthru: assert ({flags_out[4], flags_out[3], flags_out[1]} == {flags_in[4], flags_in[3], flags_in[1]})
        else $error("R6 pass-through bits changed");
      a_r7_trap_matches_c: assert (out_of_range == flags_out[0])
        else $error("R7 out_of_range differs from C");
      a_r4_bound_hit_sets_z: assert (!((ext_val == ext_lo) || (ext_val == ext_hi)) || flags_out[2])
        else $error("R4 Z clear on a bound");
      a_r5_low_bound_inside: assert (!(ext_val == ext_lo) || !flags_out[0])
        else $error("R5 C set at lower bound");
      a_r3_addr_full_width: assert (!addr_reg || (ext_val == reg_val))
        else $error("R3 address value altered");
      a_r1_long_unchanged: assert (!(size_sel[1] && !addr_reg) || (ext_val == reg_val))
        else $error("R1 long value altered");
    end
  end
endmodule

bind bchk_unit bchk_unit_chk u_chk (
  .reg_val(reg_val), .size_sel(size_sel), .addr_reg(addr_reg),
  .flags_in(flags_in), .flags_out(flags_out), .out_of_range(out_of_range),
  .ext_val(ext_val), .ext_lo(ext_lo), .ext_hi(ext_hi)
);

// File: tb/bchk_unit_test.sv
`timescale 1ns/1ps
module bchk_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] reg_val = 0, bound_lo = 0, bound_hi = 0;
  logic [1:0]  size_sel = 2;
  logic        addr_reg = 0;
  logic [4:0]  flags_in = 0;
  logic [4:0]  flags_out;
  logic        out_of_range;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bchk_unit uut (
    .reg_val(reg_val), .bound_lo(bound_lo), .bound_hi(bound_hi), .size_sel(size_sel),
    .addr_reg(addr_reg), .flags_in(flags_in), .flags_out(flags_out), .out_of_range(out_of_range)
  );

  function automatic longint widen(input logic [31:0] x, input int sz);
    byte     b;
    shortint s;
    b = x[7:0];
    s = x[15:0];
    if (sz == 0) return longint'(b) & 64'hFFFF_FFFF;
    if (sz == 1) return longint'(s) & 64'hFFFF_FFFF;
    return longint'(x);
  endfunction

  task automatic apply(input logic [31:0] v, input logic [31:0] lo, input logic [31:0] hi,
                       input int sz, input bit ar, input logic [4:0] fi, input string req);
    longint ev, el, eh, off, spn;
    bit ez, ec;
    logic [4:0] expf;
    @(negedge clk);
    reg_val = v; bound_lo = lo; bound_hi = hi; size_sel = sz[1:0]; addr_reg = ar; flags_in = fi;
    ev  = ar ? longint'(v) : widen(v, sz);
    el  = widen(lo, sz);
    eh  = widen(hi, sz);
    off = (ev - el) & 64'hFFFF_FFFF;
    spn = (eh - el) & 64'hFFFF_FFFF;
    ez  = (ev == el) || (ev == eh);
    ec  = off > spn;
    expf = {fi[4], fi[3], ez, fi[1], ec};
    @(posedge clk);
    #1;
    checks++;
    if (flags_out !== expf || out_of_range !== ec) begin
      errors++;
      $display("FAIL %s: v=%h lo=%h hi=%h sz=%0d ar=%0b flags=%b oor=%b expected flags=%b oor=%b",
               req, v, lo, hi, sz, ar, flags_out, out_of_range, expf, ec);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    apply(0, 0, 0, 2, 0, 5'b00000, "R4 idle-state zero inputs");
    apply(32'd5, 32'd1, 32'd9, 2, 0, 5'b11010, "R5 inside long");
    apply(32'd0, 32'd1, 32'd9, 2, 0, 5'b00000, "R5 below lower");
    apply(32'd10, 32'd1, 32'd9, 2, 0, 5'b11111, "R5 above upper");
    apply(32'd9, 32'd1, 32'd9, 2, 0, 5'b00100, "R4 on upper bound");
    apply(32'd1, 32'd1, 32'd9, 3, 0, 5'b00001, "R4 on lower bound size 3");
    apply(32'd7, 32'd10, 32'd5, 2, 0, 5'b00000, "R5 reversed pair gap");
    apply(32'd12, 32'd10, 32'd5, 2, 0, 5'b00000, "R5 reversed pair wrap");
    apply(32'h0000_00FF, 32'h0000_0080, 32'h0000_007F, 0, 0, 5'b00000, "R1 byte bounds sign-extended");
    apply(32'hFFFF_FFF0, 32'hAAAA_00F0, 32'h5555_0010, 0, 0, 5'b10000, "R8 byte high bits ignored");
    apply(32'h1234_FFF0, 32'h0000_FF00, 32'hFFFF_0100, 1, 0, 5'b01000, "R2 word data sign-extended");
    apply(32'h0000_0080, 32'h0000_0080, 32'h0000_007F, 0, 0, 5'b00000, "R2 byte data 0x80 negative");
    apply(32'h0000_0080, 32'h0000_0080, 32'h0000_007F, 0, 1, 5'b00000, "R3 address byte full width");
    apply(32'hFFFF_FF80, 32'h0000_0080, 32'h0000_00FF, 0, 1, 5'b00000, "R3 address equals extended bound");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0001, 2, 0, 5'b00010, "R5 signed wrap inside");
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 2, 0, 5'b11011, "R6 flags kept single point");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v, lo, hi;
      int sz;
      lo = $urandom; hi = $urandom; v = $urandom;
      sz = $urandom_range(0, 3);
      if (i % 4 == 1) v = {$urandom} ^ {24'd0, lo[7:0]} ^ {lo[31:8], 8'd0} ^ {$urandom} ^ lo;
      if (i % 5 == 2) v = hi;
      if (i % 7 == 3) hi = lo + $urandom_range(0, 3);
      apply(v, lo, hi, sz, $urandom_range(0, 1) == 1, 5'($urandom), "R4/R5/R6/R7/R8 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule